// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Sequencer

This block sits beside a program sequencer and runs hardware loops without spending cycles on branches. A block loop is opened by a start command that carries an iteration count and the absolute address of the body's last instruction. The fetch address seen in that same cycle is taken as the body's first instruction and stored with the loop. Each time fetch reaches the stored last address, the block either sends fetch back to the stored first address in that same cycle or lets it fall through once the count runs out.

A second mode repeats one instruction. It loads a private down-counter, asks the fetch unit to hold its address while repetitions remain, and never touches the loop stack. Loops can be nested up to the stack depth. An early-exit command abandons the innermost loop and brings the enclosing one back. Software can overwrite the innermost count; a write of 1 lets the loop end cleanly at its next pass over the last address.

Top module: `hwloop_seq`

## Requirements
- R1: A block-start command with a nonzero count, issued while the stack is not full, adds one stack level from the next cycle. loop_active is then 1 and loop_count shows the given count. The cycle's fetch_addr is saved as the loop's first address, and no redirect is raised in the command cycle.
- R2: When fetch_addr equals the innermost loop's last address and its count is above 1, redirect_valid is 1 in that same cycle with redirect_addr equal to the saved first address, and loop_count is one lower from the next cycle.
- R3: When fetch_addr equals the innermost loop's last address and its count is 1 or less, no redirect is raised and that loop leaves the stack in the next cycle. The enclosing loop's count is then shown; with none left, loop_active and loop_count become 0.
- R4: An early-exit command removes the innermost loop without a redirect, and the enclosing loop resumes with its own count and addresses. On an empty stack the command has no effect.
- R5: A loop-counter write replaces the innermost loop's count from the next cycle. After a write of 1, the next match on the last address falls through with no redirect and the loop ends.
- R6: A block-start command with a count of 0 pushes nothing and raises redirect_valid in the same cycle, with redirect_addr equal to the given last address plus 1.
- R7: With two loops nested, end matches act on the inner loop until it finishes, and the outer loop's end match then redirects to the outer first address.
- R8: A block-start command with a nonzero count while the stack is full leaves the stack unchanged and sets stack_ovf, which stays 1 until reset.
- R9: A repeat command with count N of 1 or more, accepted while no repeat is running, makes rpt_active 1 for the next N cycles. hold_fetch is 1 in the first N-1 of those cycles, and stack_depth does not change.
- R10: A repeat command with a count of 0 raises redirect_valid in the same cycle, with redirect_addr equal to fetch_addr plus 1.
- R11: While hold_fetch is 1, the end-address check is off. It applies again in the final repetition cycle, when hold_fetch is 0.
- R12: Commands in one cycle are ranked early-exit first, then block start, then repeat, then the end check. A repeat command that arrives while a repeat is running is ignored.
- R13: After reset, redirect_valid, hold_fetch, loop_active, loop_count, rpt_active, stack_depth and stack_ovf are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| blk_start | input | 1 | Open a block loop this cycle |
| blk_count | input | 16 | Iteration count for the block loop |
| blk_end | input | 16 | Absolute address of the body's last instruction |
| rpt_start | input | 1 | Start a single-instruction repeat |
| rpt_count | input | 16 | Repeat count |
| loop_break | input | 1 | Abandon the innermost block loop |
| lc_wr | input | 1 | Write the innermost loop count |
| lc_wdata | input | 16 | Value for the loop-count write |
| fetch_addr | input | 16 | Address being fetched this cycle |
| redirect_valid | output | 1 | Override the next fetch address |
| redirect_addr | output | 16 | Next fetch address when redirect_valid is 1 |
| hold_fetch | output | 1 | Keep the current fetch address for another cycle |
| loop_active | output | 1 | At least one block loop is open |
| loop_count | output | 16 | Remaining count of the innermost block loop |
| rpt_active | output | 1 | A repeat is running |
| stack_depth | output | 2 | Number of open block loops |
| stack_ovf | output | 1 | Sticky flag: a block start found the stack full |

## Verification
The in-line properties watch, on every cycle, how stack depth moves on each push and pop, the one-step count decrement on an iterating end match, the repeat counter stepping down, the quiet behaviour of the end check while fetch is held, the stable depth on a zero-count start, and the stickiness of the overflow flag. Whether a redirect goes to the right address, whether an outer loop's parameters really come back after an inner exit, and how a write of 1 plays out over a whole body pass are only shown by the bench's directed scenarios. The same holds for the last repetition handing over to a loop's end check, and for the ranking of colliding commands.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned CNT_W  = 16;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // One open block loop: body bounds and remaining passes
  typedef struct packed {
    addr_t first;
    addr_t last;
    cnt_t  remain;
  } loop_ent_t;
endpackage

// File: rtl/hwloop_stack.sv
module hwloop_stack
  import hwloop_pkg::*;
#(
  parameter  int unsigned DEPTH = 2,
  localparam int unsigned SPW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            push_i,
  input  loop_ent_t       push_ent_i,
  input  logic            pop_i,
  input  logic            dec_i,
  input  logic            wr_i,
  input  cnt_t            wr_cnt_i,
  output loop_ent_t       top_o,
  output logic [SPW-1:0]  depth_o,
  output logic            empty_o,
  output logic            full_o
);

  logic [SPW-1:0] sp_q, sp_nxt;
  logic           sp_en;
  loop_ent_t      ent_q [DEPTH];

  assign depth_o = sp_q;
  assign empty_o = (sp_q == '0);
  assign full_o  = (sp_q == SPW'(DEPTH));

  // Pointer next state
  always_comb begin
    sp_nxt = sp_q;
    sp_en  = 1'b0;
    if (push_i && !full_o) begin
      sp_nxt = sp_q + SPW'(1);
      sp_en  = 1'b1;
    end else if (pop_i && !empty_o) begin
      sp_nxt = sp_q - SPW'(1);
      sp_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
    end else if (sp_en) begin
      sp_q <= sp_nxt;
    end
  end

  // Per-level storage; the innermost level also owns the live count
  for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
    loop_ent_t q, nxt;
    logic      en;

    always_comb begin
      nxt = q;
      en  = 1'b0;
      if (push_i && !full_o && (sp_q == SPW'(g))) begin
        nxt = push_ent_i;
        en  = 1'b1;
      end else if (sp_q == SPW'(g + 1)) begin
        if (wr_i) begin
          nxt.remain = wr_cnt_i;
          en         = 1'b1;
        end else if (dec_i) begin
          nxt.remain = q.remain - cnt_t'(1);
          en         = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (en) begin
        q <= nxt;
      end
    end

    assign ent_q[g] = q;
  end

  // Innermost level view, zero when nothing is open
  always_comb begin
    top_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (sp_q == SPW'(k + 1)) begin
        top_o = ent_q[k];
      end
    end
  end

  AST_PUSH_DEPTH: assert property (@(posedge clk) disable iff (!rst_ni)
    (push_i && !full_o) |=> (depth_o == $past(depth_o) + SPW'(1)))
    else $error("push did not add a level"); // R1

  AST_POP_DEPTH: assert property (@(posedge clk) disable iff (!rst_ni)
    (pop_i && !push_i && !empty_o) |=> (depth_o == $past(depth_o) - SPW'(1)))
    else $error("pop did not remove a level"); // R3

  AST_DEC_COUNT: assert property (@(posedge clk) disable iff (!rst_ni)
    (dec_i && !wr_i && !push_i && !pop_i && !empty_o)
      |=> (top_o.remain == $past(top_o.remain) - cnt_t'(1)))
    else $error("iteration did not lower the count by one"); // R2

  AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_ni)
    (push_i && !pop_i && full_o) |=> $stable(depth_o))
    else $error("push on a full stack changed depth"); // R8

endmodule

// File: rtl/hwloop_rep.sv
module hwloop_rep
  import hwloop_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic load_i,
  input  cnt_t load_cnt_i,
  output logic active_o,
  output logic hold_o
);

  cnt_t rc_q, rc_nxt;
  logic rc_en;

  always_comb begin
    rc_nxt = rc_q;
    rc_en  = 1'b0;
    if (load_i) begin
      rc_nxt = load_cnt_i;
      rc_en  = 1'b1;
    end else if (rc_q != '0) begin
      rc_nxt = rc_q - cnt_t'(1);
      rc_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rc_q <= '0;
    end else if (rc_en) begin
      rc_q <= rc_nxt;
    end
  end

  assign active_o = (rc_q != '0);
  assign hold_o   = (rc_q > cnt_t'(1));

  AST_REP_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_ni)
    (active_o && !load_i) |=> (rc_q == $past(rc_q) - cnt_t'(1)))
    else $error("repeat counter did not step down"); // R9

  AST_REP_LAST: assert property (@(posedge clk) disable iff (!rst_ni)
    (active_o && !hold_o && !load_i) |=> !active_o)
    else $error("repeat outlived its final cycle"); // R9

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
(
  input  logic      blk_start_i,
  input  cnt_t      blk_cnt_i,
  input  addr_t     blk_end_i,
  input  logic      rpt_start_i,
  input  cnt_t      rpt_cnt_i,
  input  logic      brk_i,
  input  logic      lc_wr_i,
  input  cnt_t      lc_data_i,
  input  addr_t     fetch_i,
  input  loop_ent_t top_i,
  input  logic      empty_i,
  input  logic      full_i,
  input  logic      rpt_active_i,
  input  logic      rpt_hold_i,
  output logic      push_o,
  output loop_ent_t push_ent_o,
  output logic      pop_o,
  output logic      dec_o,
  output logic      wr_o,
  output cnt_t      wr_cnt_o,
  output logic      rpt_load_o,
  output logic      ovf_set_o,
  output logic      redir_o,
  output addr_t     redir_addr_o
);

  logic end_hit;

  assign end_hit = !empty_i && !rpt_hold_i && (fetch_i == top_i.last);

  // Ranked decision: exit, block start, repeat start, end check
  always_comb begin
    push_o       = 1'b0;
    pop_o        = 1'b0;
    dec_o        = 1'b0;
    rpt_load_o   = 1'b0;
    ovf_set_o    = 1'b0;
    redir_o      = 1'b0;
    redir_addr_o = '0;
    push_ent_o   = '{first: fetch_i, last: blk_end_i, remain: blk_cnt_i};
    wr_cnt_o     = lc_data_i;

    if (brk_i) begin
      pop_o = !empty_i;
    end else if (blk_start_i) begin
      if (blk_cnt_i == '0) begin
        redir_o      = 1'b1;
        redir_addr_o = blk_end_i + addr_t'(1);
      end else if (full_i) begin
        ovf_set_o = 1'b1;
      end else begin
        push_o = 1'b1;
      end
    end else if (rpt_start_i && !rpt_active_i) begin
      if (rpt_cnt_i == '0) begin
        redir_o      = 1'b1;
        redir_addr_o = fetch_i + addr_t'(1);
      end else begin
        rpt_load_o = 1'b1;
      end
    end else if (end_hit) begin
      if (top_i.remain > cnt_t'(1)) begin
        redir_o      = 1'b1;
        redir_addr_o = top_i.first;
        dec_o        = 1'b1;
      end else begin
        pop_o = 1'b1;
      end
    end

    wr_o = lc_wr_i && !empty_i && !pop_o;
  end

endmodule

// File: rtl/hwloop_seq.sv
module hwloop_seq
  import hwloop_pkg::*;
#(
  parameter  int unsigned DEPTH = 2,
  localparam int unsigned SPW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_start,
  input  logic [CNT_W-1:0]  blk_count,
  input  logic [ADDR_W-1:0] blk_end,
  input  logic              rpt_start,
  input  logic [CNT_W-1:0]  rpt_count,
  input  logic              loop_break,
  input  logic              lc_wr,
  input  logic [CNT_W-1:0]  lc_wdata,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_addr,
  output logic              hold_fetch,
  output logic              loop_active,
  output logic [CNT_W-1:0]  loop_count,
  output logic              rpt_active,
  output logic [SPW-1:0]    stack_depth,
  output logic              stack_ovf
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_int = rsync_q[1];

  loop_ent_t top_ent, push_ent;
  logic      push, pop, dec, wr, rpt_load, ovf_set;
  logic      st_empty, st_full, rp_active, rp_hold;
  cnt_t      wr_cnt;
  logic      ovf_q, ovf_nxt, ovf_en;

  hwloop_ctrl u_ctrl (
    .blk_start_i  (blk_start),
    .blk_cnt_i    (blk_count),
    .blk_end_i    (blk_end),
    .rpt_start_i  (rpt_start),
    .rpt_cnt_i    (rpt_count),
    .brk_i        (loop_break),
    .lc_wr_i      (lc_wr),
    .lc_data_i    (lc_wdata),
    .fetch_i      (fetch_addr),
    .top_i        (top_ent),
    .empty_i      (st_empty),
    .full_i       (st_full),
    .rpt_active_i (rp_active),
    .rpt_hold_i   (rp_hold),
    .push_o       (push),
    .push_ent_o   (push_ent),
    .pop_o        (pop),
    .dec_o        (dec),
    .wr_o         (wr),
    .wr_cnt_o     (wr_cnt),
    .rpt_load_o   (rpt_load),
    .ovf_set_o    (ovf_set),
    .redir_o      (redirect_valid),
    .redir_addr_o (redirect_addr)
  );

  hwloop_stack #(.DEPTH(DEPTH)) u_stack (
    .clk        (clk),
    .rst_ni     (rst_int),
    .push_i     (push),
    .push_ent_i (push_ent),
    .pop_i      (pop),
    .dec_i      (dec),
    .wr_i       (wr),
    .wr_cnt_i   (wr_cnt),
    .top_o      (top_ent),
    .depth_o    (stack_depth),
    .empty_o    (st_empty),
    .full_o     (st_full)
  );

  hwloop_rep u_rep (
    .clk        (clk),
    .rst_ni     (rst_int),
    .load_i     (rpt_load),
    .load_cnt_i (rpt_count),
    .active_o   (rp_active),
    .hold_o     (rp_hold)
  );

  // Sticky overflow flag
  always_comb begin
    ovf_nxt = ovf_q | ovf_set;
    ovf_en  = ovf_set;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      ovf_q <= 1'b0;
    end else if (ovf_en) begin
      ovf_q <= ovf_nxt;
    end
  end

  assign stack_ovf   = ovf_q;
  assign hold_fetch  = rp_hold;
  assign rpt_active  = rp_active;
  assign loop_active = !st_empty;
  assign loop_count  = top_ent.remain;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_int)
    stack_ovf |=> stack_ovf)
    else $error("overflow flag cleared without reset"); // R8

  AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_int)
    (blk_start && !loop_break && (blk_count == '0)) |=> $stable(stack_depth))
    else $error("zero-count start changed depth"); // R6

  AST_HOLD_NO_END: assert property (@(posedge clk) disable iff (!rst_int)
    (hold_fetch && !blk_start && !loop_break) |=> $stable(stack_depth))
    else $error("end check acted while fetch was held"); // R11

  AST_HOLD_NO_REDIR: assert property (@(posedge clk) disable iff (!rst_int)
    (hold_fetch && !blk_start) |-> !redirect_valid)
    else $error("redirect raised while fetch was held"); // R11

endmodule

// File: tb/hwloop_seq_bench.sv
`timescale 1ns/1ps
module hwloop_seq_bench;
  logic        clk;
  logic        rst_n;
  logic        blk_start;
  logic [15:0] blk_count;
  logic [15:0] blk_end;
  logic        rpt_start;
  logic [15:0] rpt_count;
  logic        loop_break;
  logic        lc_wr;
  logic [15:0] lc_wdata;
  logic [15:0] fetch_addr;
  logic        redirect_valid;
  logic [15:0] redirect_addr;
  logic        hold_fetch;
  logic        loop_active;
  logic [15:0] loop_count;
  logic        rpt_active;
  logic [1:0]  stack_depth;
  logic        stack_ovf;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  hwloop_seq u_hwloop_seq (
    .clk, .rst_n, .blk_start, .blk_count, .blk_end, .rpt_start, .rpt_count,
    .loop_break, .lc_wr, .lc_wdata, .fetch_addr, .redirect_valid,
    .redirect_addr, .hold_fetch, .loop_active, .loop_count, .rpt_active,
    .stack_depth, .stack_ovf
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    blk_start = 0; blk_count = 0; blk_end = 0;
    rpt_start = 0; rpt_count = 0; loop_break = 0;
    lc_wr = 0; lc_wdata = 0;
  endtask

  // Present a fetch address and let combinational outputs settle
  task automatic at(input logic [15:0] a);
    fetch_addr = a;
    #1;
  endtask

  // Cross one rising edge, then clear one-cycle commands
  task automatic step();
    @(posedge clk);
    #1;
    clr();
  endtask

  task automatic open_loop(input logic [15:0] first, input logic [15:0] cnt,
                           input logic [15:0] last);
    blk_start = 1; blk_count = cnt; blk_end = last;
    at(first);
    step();
  endtask

  task automatic t_reset();
    check("R13", "redirect_valid", redirect_valid, 0);
    check("R13", "hold_fetch", hold_fetch, 0);
    check("R13", "loop_active", loop_active, 0);
    check("R13", "loop_count", loop_count, 0);
    check("R13", "rpt_active", rpt_active, 0);
    check("R13", "stack_depth", stack_depth, 0);
    check("R13", "stack_ovf", stack_ovf, 0);
  endtask

  task automatic t_block();
    blk_start = 1; blk_count = 3; blk_end = 16'h0102;
    at(16'h0100);
    check("R1", "no redirect on start", redirect_valid, 0);
    step();
    check("R1", "active", loop_active, 1);
    check("R1", "count", loop_count, 3);
    check("R1", "depth", stack_depth, 1);
    for (int p = 3; p >= 1; p--) begin
      at(16'h0100); step();
      at(16'h0101); step();
      at(16'h0102);
      if (p > 1) begin
        check("R2", "redirect at end", redirect_valid, 1);
        check("R2", "redirect target", redirect_addr, 16'h0100);
        step();
        check("R2", "count lowered", loop_count, p - 1);
      end else begin
        check("R3", "fall through", redirect_valid, 0);
        step();
        check("R3", "inactive", loop_active, 0);
        check("R3", "depth", stack_depth, 0);
        check("R3", "count", loop_count, 0);
      end
    end
  endtask

  task automatic t_skip();
    blk_start = 1; blk_count = 0; blk_end = 16'h0210;
    at(16'h0200);
    check("R6", "skip redirect", redirect_valid, 1);
    check("R6", "skip target", redirect_addr, 16'h0211);
    step();
    check("R6", "nothing pushed", stack_depth, 0);
  endtask

  task automatic t_nest();
    open_loop(16'h0300, 2, 16'h030A);
    open_loop(16'h0302, 2, 16'h0304);
    check("R7", "two levels", stack_depth, 2);
    blk_start = 1; blk_count = 5; blk_end = 16'h0303;
    at(16'h0303);
    check("R8", "no redirect on overflow", redirect_valid, 0);
    step();
    check("R8", "overflow flag", stack_ovf, 1);
    check("R8", "depth kept", stack_depth, 2);
    check("R8", "inner count kept", loop_count, 2);
    at(16'h0304);
    check("R7", "inner redirect", redirect_valid, 1);
    check("R7", "inner target", redirect_addr, 16'h0302);
    step();
    at(16'h0302); step();
    at(16'h0303); step();
    at(16'h0304);
    check("R7", "inner ends", redirect_valid, 0);
    step();
    check("R7", "outer restored depth", stack_depth, 1);
    check("R7", "outer restored count", loop_count, 2);
    at(16'h030A);
    check("R7", "outer redirect", redirect_valid, 1);
    check("R7", "outer target", redirect_addr, 16'h0300);
    step();
    loop_break = 1;
    at(16'h0300);
    check("R4", "no redirect on exit", redirect_valid, 0);
    step();
    check("R4", "exit empties", loop_active, 0);
    check("R8", "flag sticky", stack_ovf, 1);
    loop_break = 1;
    at(16'h0400);
    check("R4", "exit on empty", redirect_valid, 0);
    step();
    check("R4", "empty stays empty", stack_depth, 0);
  endtask

  task automatic t_break();
    open_loop(16'h0500, 4, 16'h0510);
    open_loop(16'h0501, 3, 16'h0505);
    loop_break = 1;
    at(16'h0502);
    check("R4", "no redirect", redirect_valid, 0);
    step();
    check("R4", "outer depth", stack_depth, 1);
    check("R4", "outer count", loop_count, 4);
    at(16'h0505);
    check("R4", "old inner end ignored", redirect_valid, 0);
    step();
    at(16'h0510);
    check("R4", "outer redirect", redirect_addr, 16'h0500);
    step();
    loop_break = 1; at(16'h0500); step();
  endtask

  task automatic t_lcwr();
    open_loop(16'h0600, 10, 16'h0602);
    lc_wr = 1; lc_wdata = 1;
    at(16'h0601);
    step();
    check("R5", "count written", loop_count, 1);
    check("R5", "still active", loop_active, 1);
    at(16'h0602);
    check("R5", "clean finish", redirect_valid, 0);
    step();
    check("R5", "loop ended", loop_active, 0);
  endtask

  task automatic t_rep();
    rpt_start = 1; rpt_count = 3;
    at(16'h0700);
    check("R9", "no redirect", redirect_valid, 0);
    step();
    check("R9", "active 1", rpt_active, 1);
    check("R9", "hold 1", hold_fetch, 1);
    step();
    check("R9", "hold 2", hold_fetch, 1);
    step();
    check("R9", "last active", rpt_active, 1);
    check("R9", "last not held", hold_fetch, 0);
    step();
    check("R9", "repeat done", rpt_active, 0);
    check("R9", "stack untouched", stack_depth, 0);
    rpt_start = 1; rpt_count = 0;
    at(16'h0710);
    check("R10", "skip redirect", redirect_valid, 1);
    check("R10", "skip target", redirect_addr, 16'h0711);
    step();
    check("R10", "no repeat", rpt_active, 0);
  endtask

  task automatic t_rep_in_loop();
    open_loop(16'h0800, 2, 16'h0801);
    rpt_start = 1; rpt_count = 3;
    at(16'h0801);
    check("R11", "no end check on command", redirect_valid, 0);
    step();
    at(16'h0801);
    check("R11", "held, no redirect", redirect_valid, 0);
    step();
    at(16'h0801);
    check("R11", "held again", redirect_valid, 0);
    step();
    at(16'h0801);
    check("R11", "final rep redirect", redirect_valid, 1);
    check("R11", "final rep target", redirect_addr, 16'h0800);
    step();
    check("R11", "count lowered", loop_count, 1);
    loop_break = 1; at(16'h0800); step();
  endtask

  task automatic t_priority();
    open_loop(16'h0900, 2, 16'h0905);
    loop_break = 1; blk_start = 1; blk_count = 4; blk_end = 16'h0999;
    at(16'h0901);
    step();
    check("R12", "exit beats start", stack_depth, 0);
    rpt_start = 1; rpt_count = 5;
    at(16'h0A00);
    step();
    rpt_start = 1; rpt_count = 2;
    at(16'h0A00);
    step();
    step();
    step();
    check("R12", "reload ignored active", rpt_active, 1);
    check("R12", "reload ignored hold", hold_fetch, 1);
    step(); step(); step();
    check("R12", "repeat drained", rpt_active, 0);
  endtask

  initial begin
    clr();
    fetch_addr = 16'hFFFF;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_block();
    t_skip();
    t_nest();
    t_break();
    t_lcwr();
    t_rep();
    t_rep_in_loop();
    t_priority();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule